// File: doc/BRIEF.md
# Keyed Extension Gate with Identity Readback

This block is a small register file on an 8-bit indexed I/O bus in the style of a VGA adapter. It has two index/data port pairs: a sequencer pair at 3C4h/3C5h and a CRT controller pair at 3D4h/3D5h. Each pair latches an 8-bit index on a write to its index port. A write or read on the data port then reaches the register that index selects.

A bank of extended sequencer registers stays locked until software writes a magic key byte to one sequencer index. A second magic byte at that index locks the bank again. Two read-only values help software recognise the device. The first is an identity value on the CRT side, formed by XORing a scratch CRT register with the unlock key. Software can write a test pattern to the scratch register, read the identity value back, and then restore the scratch register. The second is a revision byte on the sequencer side, fixed by a module parameter and visible only while the bank is unlocked.

A 16-bit write to the sequencer index port loads the index and the data in one bus cycle. This lets software unlock or lock the extended bank with a single word write.

Top module: `xgate_top`

## Requirements
- R1: After a synchronous reset, the extensions are locked. Both index registers read 00h, and every storage register reads 00h.
- R2: Each index register is 8 bits wide. It reads back unchanged at its own index port (3C4h or 3D4h) until the next write to that port.
- R3: Writing EAh to sequencer index 06h unlocks the extensions. While they are unlocked, a data read at sequencer index 06h returns 01h.
- R4: Writing AEh to sequencer index 06h locks the extensions, after which index 06h reads 00h. Any other byte written to index 06h leaves the lock state unchanged.
- R5: While the extensions are locked, writes to sequencer indices E0h–FFh are ignored, and data reads of those indices return 00h.
- R6: While the extensions are unlocked, sequencer indices E0h–FFh are independent 8-bit read/write registers.
- R7: Sequencer index 8Eh returns the REVISION parameter while unlocked and 00h while locked. Writes to it never change it. The default revision lies in 50h–59h, the range that marks a version-5 class device.
- R8: CRT index 0Ch is an ordinary read/write register. Writing back a previously read value restores it exactly.
- R9: CRT index 1Fh reads as the contents of CRT index 0Ch XOR EAh, whether the extensions are locked or unlocked. For example, 55h in 0Ch reads as BFh. Writes to 1Fh have no effect.
- R10: A 16-bit write to 3C4h (io_wide=1) puts bits 7:0 into the sequencer index and applies bits 15:8 as data to that new index, all in one cycle.
- R11: Sequencer indices 00h–07h (other than 06h) and CRT indices 00h–18h are plain storage. All other unlisted indices read 00h, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wide | input | 1 | 16-bit write (used at 3C4h only) |
| io_wdata | input | 16 | Write data; only bits 7:0 are used unless io_wide is set |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Combinational read data; 00h when no read is active or the address is not decoded |

## Verification
The bench goes after the key index itself:
- A design that stores non-key bytes at index 06h, or lets them toggle the lock, would read back the wrong lock flag.
- A design that does not gate the extended bank would let writes made while locked reappear after unlocking.

It replays the identification sequence and checks that the identity value follows every new scratch value. A stale or unXORed identity would show up as a wrong byte.

Word writes to 3C4h check that the data goes to the newly written index and not to the old one. A design that used the old index would corrupt a different register.

Mixed random traffic across all four ports then compares every read with a bench model.

// File: rtl/xgate_pkg.sv
package xgate_pkg;

    localparam logic [7:0] KEY_OPEN_DEF  = 8'hEA;
    localparam logic [7:0] KEY_CLOSE_DEF = 8'hAE;

    typedef enum logic [2:0] {
        PSEL_NONE,
        PSEL_SEQ_IDX,
        PSEL_SEQ_DAT,
        PSEL_CRT_IDX,
        PSEL_CRT_DAT
    } port_sel_e;

    typedef struct packed {
        logic       idx_we;
        logic       dat_we;
        logic [7:0] idx;
        logic [7:0] dat;
    } bank_wr_t;

    function automatic logic [7:0] target_index(input bank_wr_t w, input logic [7:0] held);
        return w.idx_we ? w.idx : held;
    endfunction

    function automatic logic in_window(input logic [7:0] v, input logic [7:0] lo, input int n);
        return ({1'b0, v} >= {1'b0, lo}) && (int'(v) < int'(lo) + n);
    endfunction

endpackage

// File: rtl/xgate_decode.sv
module xgate_decode
    import xgate_pkg::*;
#(
    parameter logic [15:0] SEQ_PORT = 16'h03C4,
    parameter logic [15:0] CRT_PORT = 16'h03D4
) (
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_wide,
    input  logic [15:0] io_wdata,
    output bank_wr_t    seq_w,
    output bank_wr_t    crt_w,
    output port_sel_e   rsel
);
    localparam logic [15:0] SEQ_DPORT = SEQ_PORT + 16'd1;
    localparam logic [15:0] CRT_DPORT = CRT_PORT + 16'd1;

    logic hit_si, hit_sd, hit_ci, hit_cd;

    always_comb begin
        hit_si = (io_addr == SEQ_PORT);
        hit_sd = (io_addr == SEQ_DPORT);
        hit_ci = (io_addr == CRT_PORT);
        hit_cd = (io_addr == CRT_DPORT);

        seq_w.idx_we = io_wr && hit_si;
        seq_w.idx    = io_wdata[7:0];
        seq_w.dat_we = io_wr && (hit_sd || (hit_si && io_wide));
        seq_w.dat    = hit_si ? io_wdata[15:8] : io_wdata[7:0];

        crt_w.idx_we = io_wr && hit_ci;
        crt_w.idx    = io_wdata[7:0];
        crt_w.dat_we = io_wr && hit_cd;
        crt_w.dat    = io_wdata[7:0];

        if (hit_si)      rsel = PSEL_SEQ_IDX;
        else if (hit_sd) rsel = PSEL_SEQ_DAT;
        else if (hit_ci) rsel = PSEL_CRT_IDX;
        else if (hit_cd) rsel = PSEL_CRT_DAT;
        else             rsel = PSEL_NONE;
    end
endmodule

// File: rtl/xgate_seq_bank.sv
module xgate_seq_bank
    import xgate_pkg::*;
#(
    parameter int         STD_N     = 8,
    parameter logic [7:0] KEY_IDX   = 8'h06,
    parameter logic [7:0] KEY_OPEN  = KEY_OPEN_DEF,
    parameter logic [7:0] KEY_CLOSE = KEY_CLOSE_DEF,
    parameter logic [7:0] REV_IDX   = 8'h8E,
    parameter logic [7:0] REVISION  = 8'h54,
    parameter logic [7:0] EXT_BASE  = 8'hE0
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_wr_t   w,
    output logic [7:0] idx_q,
    output logic [7:0] rd_data,
    output logic       ext_en
);
    localparam int EXT_N = 256 - int'(EXT_BASE);
    localparam int EW    = (EXT_N > 1) ? $clog2(EXT_N) : 1;
    localparam int SW    = (STD_N > 1) ? $clog2(STD_N) : 1;

    logic [7:0]       std_q [STD_N];
    logic [EXT_N-1:0][7:0] ext_q;
    logic [7:0]       tgt;
    logic [7:0]       rd_off;
    logic             key_hit;

    assign tgt     = target_index(w, idx_q);
    assign key_hit = w.dat_we && (tgt == KEY_IDX);
    assign rd_off  = idx_q - EXT_BASE;

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else if (w.idx_we) idx_q <= w.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) ext_en <= 1'b0;
        else if (key_hit && w.dat == KEY_OPEN) ext_en <= 1'b1;
        else if (key_hit && w.dat == KEY_CLOSE) ext_en <= 1'b0;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < STD_N; k++) begin
            if (rst) std_q[k] <= '0;
            else if (w.dat_we && tgt == 8'(k) && tgt != KEY_IDX) std_q[k] <= w.dat;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < EXT_N; k++) begin
            if (rst) ext_q[k] <= '0;
            else if (ext_en && w.dat_we && tgt == 8'(int'(EXT_BASE) + k)) ext_q[k] <= w.dat;
        end
    end

    always_comb begin
        rd_data = '0;
        if (idx_q == KEY_IDX)                    rd_data = {7'b0, ext_en};
        else if (in_window(idx_q, 8'h00, STD_N)) rd_data = std_q[idx_q[SW-1:0]];
        else if (idx_q == REV_IDX)               rd_data = ext_en ? REVISION : 8'h00;
        else if (in_window(idx_q, EXT_BASE, EXT_N)) rd_data = ext_en ? ext_q[rd_off[EW-1:0]] : 8'h00;
    end

    // R3: the open key unlocks on the next cycle
    assert_key_open_R3: assert property (@(posedge clk) disable iff (rst)
        (key_hit && w.dat == KEY_OPEN) |=> ext_en);

    // R4: the close key locks on the next cycle
    assert_key_close_R4: assert property (@(posedge clk) disable iff (rst)
        (key_hit && w.dat == KEY_CLOSE) |=> !ext_en);

    // R4: without a key write, the lock state holds
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(key_hit && (w.dat == KEY_OPEN || w.dat == KEY_CLOSE)) |=> $stable(ext_en));

    // R5: the extended bank is frozen while locked
    assert_locked_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        !ext_en |=> $stable(ext_q));

    // R10: a wide write lands its data at the new index
    assert_wide_target_R10: assert property (@(posedge clk) disable iff (rst)
        (w.idx_we && w.dat_we && w.idx == EXT_BASE && ext_en) |=> (ext_q[0] == $past(w.dat)));
endmodule

// File: rtl/xgate_crt_bank.sv
module xgate_crt_bank
    import xgate_pkg::*;
#(
    parameter int         STD_N       = 25,
    parameter logic [7:0] SCRATCH_IDX = 8'h0C,
    parameter logic [7:0] ID_IDX      = 8'h1F,
    parameter logic [7:0] KEY_OPEN    = KEY_OPEN_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_wr_t   w,
    output logic [7:0] idx_q,
    output logic [7:0] rd_data
);
    localparam int SW = (STD_N > 1) ? $clog2(STD_N) : 1;

    logic [7:0] std_q [STD_N];
    logic [7:0] tgt;
    logic [7:0] id_val;

    assign tgt    = target_index(w, idx_q);
    assign id_val = std_q[SCRATCH_IDX[SW-1:0]] ^ KEY_OPEN;

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else if (w.idx_we) idx_q <= w.idx;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < STD_N; k++) begin
            if (rst) std_q[k] <= '0;
            else if (w.dat_we && tgt == 8'(k)) std_q[k] <= w.dat;
        end
    end

    always_comb begin
        rd_data = '0;
        if (in_window(idx_q, 8'h00, STD_N)) rd_data = std_q[idx_q[SW-1:0]];
        else if (idx_q == ID_IDX)           rd_data = id_val;
    end

    // R9: the identity value follows each new scratch value
    assert_id_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        (w.dat_we && tgt == SCRATCH_IDX) |=> (id_val == ($past(w.dat) ^ KEY_OPEN)));

    // R2: the index holds unless written
    assert_index_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !w.idx_we |=> $stable(idx_q));
endmodule

// File: rtl/xgate_top.sv
module xgate_top
    import xgate_pkg::*;
#(
    parameter logic [7:0] REVISION = 8'h54
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_wide,
    input  logic [15:0] io_wdata,
    input  logic        io_rd,
    output logic [7:0]  io_rdata
);
    bank_wr_t   seq_w, crt_w;
    port_sel_e  rsel;
    logic [7:0] seq_idx, seq_rd, crt_idx, crt_rd;
    logic       ext_en;

    xgate_decode u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_wide (io_wide),
        .io_wdata(io_wdata),
        .seq_w   (seq_w),
        .crt_w   (crt_w),
        .rsel    (rsel)
    );

    xgate_seq_bank #(.REVISION(REVISION)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .w      (seq_w),
        .idx_q  (seq_idx),
        .rd_data(seq_rd),
        .ext_en (ext_en)
    );

    xgate_crt_bank u_crt (
        .clk    (clk),
        .rst    (rst),
        .w      (crt_w),
        .idx_q  (crt_idx),
        .rd_data(crt_rd)
    );

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            unique case (rsel)
                PSEL_SEQ_IDX: io_rdata = seq_idx;
                PSEL_SEQ_DAT: io_rdata = seq_rd;
                PSEL_CRT_IDX: io_rdata = crt_idx;
                PSEL_CRT_DAT: io_rdata = crt_rd;
                default:      io_rdata = '0;
            endcase
        end
    end

    // R1: reset leaves the bank locked
    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ext_en);
endmodule

// File: tb/test_xgate_top.sv
module test_xgate_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] REV = 8'h57;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_wide = 1'b0;
    logic [15:0] io_wdata = '0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_sidx, m_cidx;
    logic       m_en;
    logic [7:0] m_sstd [8];
    logic [7:0] m_ext  [32];
    logic [7:0] m_crt  [25];

    always #(CLK_PERIOD/2) clk = ~clk;

    xgate_top #(.REVISION(REV)) i_xgate_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wide(io_wide),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata)
    );

    function automatic logic [7:0] exp_seq(input logic [7:0] i);
        if (i == 8'h06) return {7'b0, m_en};
        if (i < 8'h08)  return m_sstd[i[2:0]];
        if (i == 8'h8E) return m_en ? REV : 8'h00;
        if (i >= 8'hE0) return m_en ? m_ext[i[4:0]] : 8'h00;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_crt(input logic [7:0] i);
        if (i < 8'd25)  return m_crt[i[4:0]];
        if (i == 8'h1F) return m_crt[12] ^ 8'hEA;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_port(input logic [15:0] a);
        case (a)
            16'h03C4: return m_sidx;
            16'h03C5: return exp_seq(m_sidx);
            16'h03D4: return m_cidx;
            16'h03D5: return exp_crt(m_cidx);
            default:  return 8'h00;
        endcase
    endfunction

    task automatic model_seq_dat(input logic [7:0] d);
        if (m_sidx == 8'h06) begin
            if (d == 8'hEA) m_en = 1'b1;
            else if (d == 8'hAE) m_en = 1'b0;
        end else if (m_sidx < 8'h08) m_sstd[m_sidx[2:0]] = d;
        else if (m_sidx >= 8'hE0 && m_en) m_ext[m_sidx[4:0]] = d;
    endtask

    task automatic model_reset();
        m_sidx = 0; m_cidx = 0; m_en = 0;
        for (int k = 0; k < 8; k++)  m_sstd[k] = 0;
        for (int k = 0; k < 32; k++) m_ext[k] = 0;
        for (int k = 0; k < 25; k++) m_crt[k] = 0;
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic wide);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wide = wide; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_wide = 1'b0;
        case (a)
            16'h03C4: begin m_sidx = d[7:0]; if (wide) model_seq_dat(d[15:8]); end
            16'h03C5: model_seq_dat(d[7:0]);
            16'h03D4: m_cidx = d[7:0];
            16'h03D5: if (m_cidx < 8'd25) m_crt[m_cidx[4:0]] = d[7:0];
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        v = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a);
        logic [7:0] v;
        bus_rd(a, v);
        chk(req, v, exp_port(a));
    endtask

    function automatic logic [7:0] pick_idx(input int sel);
        case (sel % 6)
            0: return 8'($urandom_range(0, 7));
            1: return 8'($urandom_range(8'hE0, 8'hFF));
            2: return 8'h06;
            3: return 8'h8E;
            4: return 8'($urandom_range(0, 8'h20));
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, saved;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 seq index", 16'h03C4);
        rd_chk("R1 crt index", 16'h03D4);
        rd_chk("R1 seq data", 16'h03C5);
        bus_wr(16'h03C4, 16'h0006, 0);
        rd_chk("R1 locked flag", 16'h03C5);

        // R5 locked ext write ignored, R7 locked revision
        bus_wr(16'h03C4, 16'h00E3, 0);
        bus_wr(16'h03C5, 16'h005A, 0);
        rd_chk("R5 locked ext read", 16'h03C5);
        bus_wr(16'h03C4, 16'h008E, 0);
        rd_chk("R7 locked revision", 16'h03C5);

        // R10 wide write unlock, R3
        bus_wr(16'h03C4, 16'hEA06, 1);
        rd_chk("R10 wide index", 16'h03C4);
        rd_chk("R3 unlocked flag", 16'h03C5);
        bus_wr(16'h03C4, 16'h00E3, 0);
        rd_chk("R5 earlier locked write dropped", 16'h03C5);
        bus_wr(16'h03C4, 16'h7BE3, 1);
        rd_chk("R6 R10 ext via wide write", 16'h03C5);

        // R7 revision, write ignored
        bus_wr(16'h03C4, 16'h008E, 0);
        bus_wr(16'h03C5, 16'h0011, 0);
        bus_rd(16'h03C5, v);
        chk("R7 revision value", v, REV);
        n_chk++;
        if (!(v >= 8'h50 && v <= 8'h59)) begin
            n_fail++;
            $display("FAIL R7 range: actual %02h expected 50..59", v);
        end

        // R4 non-key byte ignored, then close
        bus_wr(16'h03C4, 16'h3306, 1);
        rd_chk("R4 other byte no effect", 16'h03C5);
        bus_wr(16'h03C4, 16'hAE06, 1);
        rd_chk("R4 closed flag", 16'h03C5);
        bus_wr(16'h03C4, 16'h00E3, 0);
        rd_chk("R5 ext hidden after lock", 16'h03C5);

        // R8 R9 identification sequence
        bus_wr(16'h03D4, 16'h000C, 0);
        bus_wr(16'h03D5, 16'h0042, 0);
        bus_rd(16'h03D5, saved);
        chk("R8 scratch store", saved, 8'h42);
        bus_wr(16'h03D5, 16'h0055, 0);
        bus_wr(16'h03D4, 16'h001F, 0);
        bus_rd(16'h03D5, v);
        chk("R9 identity BF", v, 8'hBF);
        bus_wr(16'h03D5, 16'h0000, 0);
        rd_chk("R9 write to identity ignored", 16'h03D5);
        bus_wr(16'h03D4, 16'h000C, 0);
        bus_wr(16'h03D5, {8'h00, saved}, 0);
        bus_rd(16'h03D5, v);
        chk("R8 restore", v, 8'h42);

        // R11 unimplemented and plain storage
        bus_wr(16'h03D4, 16'h0030, 0);
        bus_wr(16'h03D5, 16'h0099, 0);
        rd_chk("R11 crt unimplemented", 16'h03D5);
        bus_wr(16'h03C4, 16'h0020, 0);
        bus_wr(16'h03C5, 16'h0099, 0);
        rd_chk("R11 seq unimplemented", 16'h03C5);
        bus_wr(16'h03C4, 16'hC502, 1);
        rd_chk("R11 seq storage", 16'h03C5);

        // random traffic, R2 R6 R11
        for (int it = 0; it < 1500; it++) begin
            int op = int'($urandom_range(0, 9));
            case (op)
                0: bus_wr(16'h03C4, {8'h00, pick_idx(int'($urandom))}, 0);
                1: bus_wr(16'h03C5, {8'h00, 8'($urandom)}, 0);
                2: bus_wr(16'h03C4, {8'($urandom), pick_idx(int'($urandom))}, 1);
                3: bus_wr(16'h03D4, {8'h00, 8'($urandom_range(0, 8'h22))}, 0);
                4: bus_wr(16'h03D5, {8'h00, 8'($urandom)}, 0);
                5: bus_wr(16'h03C4, ($urandom_range(0, 1) != 0) ? 16'hEA06 : 16'hAE06, 1);
                6: rd_chk("R2 seq index", 16'h03C4);
                7: rd_chk("R6 R11 seq data", 16'h03C5);
                8: rd_chk("R2 crt index", 16'h03D4);
                default: rd_chk("R9 R11 crt data", 16'h03D5);
            endcase
        end

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        rd_chk("R1 index after reset", 16'h03C4);
        bus_wr(16'h03C4, 16'h0006, 0);
        rd_chk("R1 lock after reset", 16'h03C5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule